// File: doc/BRIEF.md
# Clock Synthesizer Configuration Front End

This block holds the divider settings of a frequency synthesizer and lets them be written through either of two ports. A three-wire serial port (serial clock, serial data, serial load) shifts a 14-bit frame into a shift register. A parallel port (9-bit loop divider value, 2-bit output divider code, parallel load) presents the dividers directly. Configuration latches take their value from one of the two sources, chosen by which load strobe is active. They drive the loop divider, output divider and test-select outputs.

All port inputs are treated as asynchronous. They are brought into a fast system clock domain through two-stage synchronizers. The latches are flops in that domain: each flop follows its source in every cycle while its strobe is active, so it behaves like a transparent latch, and it holds otherwise. The parallel port has priority. While the parallel load is low, the divider latches follow the pins and the test bits are forced to zero. Typical use: at power-on the parallel pins set a starting frequency, and the serial port later fine-tunes it or selects a test function.

Top module: `synthCfgFront`

## Requirements
- R1: After reset the outputs are loop divider 0x1FF, output divider code 2'b11 and test select 3'b000, and the shift-register tail output is 0.
- R2: On each rising edge of the serial clock, the shift register moves one place toward its tail and takes the serial data bit at the other end. The frame is sent as test select (bit 2 first), then the output divider code (bit 1 first), then the loop divider (bit 8 first, bit 0 last). After 14 shifts, the first bit sent is at bit 13 and the last is at bit 0, giving fields {test[2:0], ndiv[1:0], mdiv[8:0]} from bit 13 down.
- R3: While the serial load is high and the parallel load is high, all three outputs follow the shift register. After the serial load falls, they keep the captured value.
- R4: While the parallel load is low, the loop divider and output divider outputs follow the parallel pins. After the parallel load rises, they keep the captured value, even if the pins change.
- R5: When both strobes are active (parallel load low, serial load high), the parallel pins win and the shift register is not loaded.
- R6: The test-select output reads 3'b000 whenever the parallel load is low, even if the serial port set it to another value.
- R7: The tail output equals bit 13 of the shift register, which is the bit shifted in 14 serial clock edges earlier.
- R8: Changes on serial data without a rising serial clock edge do not change the shift register.
- R9: When neither strobe is active, shifting a new frame does not change the divider or test-select outputs.
- R10: While the serial load stays high, each new shift shows at the outputs without a further strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low reset |
| serClk | input | 1 | Serial shift clock, rising edge active |
| serData | input | 1 | Serial frame data |
| serLoad | input | 1 | Serial load strobe, latches follow the shift register while high |
| parLoad | input | 1 | Parallel load strobe, latches follow the pins while low |
| parM | input | 9 | Parallel loop divider value |
| parN | input | 2 | Parallel output divider code |
| cfgT | output | 3 | Latched test select |
| cfgN | output | 2 | Latched output divider code |
| cfgM | output | 9 | Latched loop divider value |
| srTail | output | 1 | Last stage of the shift register |

## Verification
A misplaced or lost bit in the shift register shows on the tail output within a few system cycles of the next serial clock edge. It also shows on the divider outputs as soon as a serial load pulse passes through the synchronizers. A wrong priority decision or a missed test-bit clear shows within about three system cycles of the parallel strobe changing. A latch that fails to hold shows in the next cycle after an unloaded frame or a pin change. The bench therefore checks each output a fixed, small number of cycles after every strobe or shift.

// File: rtl/synthCfgPkg.sv
package synthCfgPkg;
  // strobes from control to datapath, one per system cycle
  typedef struct packed {
    logic shiftEn;   // one serial bit enters the shift register
    logic serLatch;  // latches follow the shift register
    logic parLatch;  // latches follow the parallel pins, test bits cleared
  } cfgStrobe_t;
endpackage

// File: rtl/cfgSync.sv
module cfgSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/synthCfgCtl.sv
module synthCfgCtl
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serLoad,
  input  logic       parLoad,
  output cfgStrobe_t strobes
);
  logic serClkS, serLoadS, parLoadS, serClkPrev;

  cfgSync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_syncClk (
    .clk(clk), .rstN(rstN), .asyncIn(serClk), .syncOut(serClkS));
  cfgSync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_syncSerLoad (
    .clk(clk), .rstN(rstN), .asyncIn(serLoad), .syncOut(serLoadS));
  cfgSync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_syncParLoad (
    .clk(clk), .rstN(rstN), .asyncIn(parLoad), .syncOut(parLoadS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkPrev <= 1'b0;
    else       serClkPrev <= serClkS;
  end

  always_comb begin
    strobes.shiftEn  = serClkS & ~serClkPrev;
    strobes.parLatch = ~parLoadS;
    strobes.serLatch = serLoadS & parLoadS;  // parallel port has priority
  end

  // R5: never both latch sources in one cycle
  assert_one_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.serLatch, strobes.parLatch}));

  // R2: one shift per serial clock rise, never two cycles in a row
  assert_single_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> !strobes.shiftEn);
endmodule

// File: rtl/synthCfgData.sv
module synthCfgData
  import synthCfgPkg::*;
#(
  parameter int T_W = 3,
  parameter int N_W = 2,
  parameter int M_W = 9,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = T_W + N_W + M_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobes,
  input  logic             serData,
  input  logic [M_W-1:0]   parM,
  input  logic [N_W-1:0]   parN,
  output logic [T_W-1:0]   cfgT,
  output logic [N_W-1:0]   cfgN,
  output logic [M_W-1:0]   cfgM,
  output logic             srTail
);
  logic               serDataS;
  logic [M_W-1:0]     parMS;
  logic [N_W-1:0]     parNS;
  logic [FRAME_W-1:0] shiftReg;
  logic [T_W-1:0]     tReg;
  logic [N_W-1:0]     nReg;
  logic [M_W-1:0]     mReg;

  cfgSync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_syncData (
    .clk(clk), .rstN(rstN), .asyncIn(serData), .syncOut(serDataS));
  // pins default high (pull-ups), so sync resets to all ones
  cfgSync #(.W(M_W + N_W), .STAGES(SYNC_STAGES), .RST_VAL({(M_W + N_W){1'b1}})) i_syncPins (
    .clk(clk), .rstN(rstN), .asyncIn({parM, parN}), .syncOut({parMS, parNS}));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], serDataS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tReg <= '0;
      nReg <= '1;
      mReg <= '1;
    end else if (strobes.parLatch) begin
      tReg <= '0;
      nReg <= parNS;
      mReg <= parMS;
    end else if (strobes.serLatch) begin
      {tReg, nReg, mReg} <= shiftReg;
    end
  end

  assign cfgT   = tReg;
  assign cfgN   = nReg;
  assign cfgM   = mReg;
  assign srTail = shiftReg[FRAME_W-1];

  // R6: test bits cleared while the parallel strobe is active
  assert_test_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.parLatch |=> (tReg == '0));

  // R4: parallel capture follows the synchronized pins
  assert_par_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.parLatch |=> (mReg == $past(parMS)) && (nReg == $past(parNS)));

  // R9: latches hold with no strobe active
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.parLatch && !strobes.serLatch) |=> $stable({tReg, nReg, mReg}));

  // R2: shift moves data one place and takes the serial bit
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> (shiftReg == {$past(shiftReg[FRAME_W-2:0]), $past(serDataS)}));

  // R8: no serial clock edge, no shift
  assert_no_shift_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn |=> $stable(shiftReg));
endmodule

// File: rtl/synthCfgFront.sv
module synthCfgFront
  import synthCfgPkg::*;
#(
  parameter int T_W = 3,
  parameter int N_W = 2,
  parameter int M_W = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           parLoad,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output logic [T_W-1:0] cfgT,
  output logic [N_W-1:0] cfgN,
  output logic [M_W-1:0] cfgM,
  output logic           srTail
);
  cfgStrobe_t strobes;

  synthCfgCtl #(.SYNC_STAGES(SYNC_STAGES)) i_ctl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad),
    .parLoad(parLoad), .strobes(strobes));

  synthCfgData #(.T_W(T_W), .N_W(N_W), .M_W(M_W), .SYNC_STAGES(SYNC_STAGES)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serData(serData),
    .parM(parM), .parN(parN), .cfgT(cfgT), .cfgN(cfgN), .cfgM(cfgM),
    .srTail(srTail));
endmodule

// File: tb/test_synthCfgFront.sv
module test_synthCfgFront;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, parLoad = 1'b1;
  logic [8:0] parM = 9'h1FF;
  logic [1:0] parN = 2'b11;
  logic [2:0] cfgT;
  logic [1:0] cfgN;
  logic [8:0] cfgM;
  logic srTail;

  int nChecks = 0;
  int nFails = 0;
  logic [13:0] modelSr = '0;

  always #2.5 clk = ~clk;

  synthCfgFront i_synthCfgFront (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parLoad(parLoad), .parM(parM), .parN(parN),
    .cfgT(cfgT), .cfgN(cfgN), .cfgM(cfgM), .srTail(srTail));

  // frames {T, N, M}, first bit sent is bit 13
  localparam logic [13:0] FRAMES [6] = '{
    {3'd1, 2'd2, 9'd200}, {3'd4, 2'd0, 9'd400}, {3'd7, 2'd3, 9'h1FF},
    {3'd0, 2'd1, 9'd0},   {3'd2, 2'd1, 9'h155}, {3'd5, 2'd2, 9'h0AA}};

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    waitCyc(4);
    serClk = 1'b1;
    waitCyc(4);
    serClk = 1'b0;
    modelSr = {modelSr[12:0], b};
  endtask

  task automatic sendFrame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) sendBit(f[i]);
    waitCyc(6);
  endtask

  task automatic pulseSerLoad();
    serLoad = 1'b1;
    waitCyc(6);
    serLoad = 1'b0;
    waitCyc(6);
  endtask

  task automatic checkOut(input string req, input logic [13:0] exp);
    check(req, {18'd0, cfgT, cfgN, cfgM}, {18'd0, exp});
  endtask

  initial begin
    logic [13:0] held;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    checkOut("R1 reset outputs", {3'b000, 2'b11, 9'h1FF});
    check("R1 reset tail", {31'd0, srTail}, 32'd0);

    // table walk: R2, R3, R7, R9
    held = {3'b000, 2'b11, 9'h1FF};
    for (int v = 0; v < 6; v++) begin
      sendFrame(FRAMES[v]);
      checkOut("R9 unloaded frame holds outputs", held);
      check("R7 tail is first bit", {31'd0, srTail}, {31'd0, FRAMES[v][13]});
      check("R2 model frame", {18'd0, modelSr}, {18'd0, FRAMES[v]});
      pulseSerLoad();
      checkOut("R3 serial capture", FRAMES[v]);
      held = FRAMES[v];
    end

    // R8: data toggles without clock edge, then a load shows same frame
    serData = 1'b1; waitCyc(5); serData = 1'b0; waitCyc(5); serData = 1'b1; waitCyc(5);
    check("R8 tail unchanged", {31'd0, srTail}, {31'd0, held[13]});
    pulseSerLoad();
    checkOut("R8 frame unchanged", held);

    // R10: transparent while serial load stays high
    serLoad = 1'b1;
    waitCyc(6);
    sendBit(1'b1);
    waitCyc(6);
    checkOut("R10 follows new shift", modelSr);
    sendBit(1'b0);
    waitCyc(6);
    checkOut("R10 follows second shift", modelSr);
    serLoad = 1'b0;
    waitCyc(6);
    held = modelSr;
    check("R6 test bits set before parallel", {29'd0, cfgT}, {29'd0, held[13:11]});

    // R4, R6: parallel transparent
    parM = 9'h0C8; parN = 2'b01; parLoad = 1'b0;
    waitCyc(6);
    checkOut("R4 parallel follow", {3'b000, 2'b01, 9'h0C8});
    check("R6 test bits cleared", {29'd0, cfgT}, 32'd0);
    parM = 9'h123; parN = 2'b10;
    waitCyc(6);
    checkOut("R4 parallel still transparent", {3'b000, 2'b10, 9'h123});

    // R5: both strobes active, parallel wins
    sendFrame({3'd6, 2'd3, 9'h0F0});
    serLoad = 1'b1;
    waitCyc(6);
    checkOut("R5 parallel priority", {3'b000, 2'b10, 9'h123});

    // R4 hold after rise, serial load low
    serLoad = 1'b0;
    waitCyc(6);
    parLoad = 1'b1;
    waitCyc(6);
    parM = 9'h001; parN = 2'b00;
    waitCyc(6);
    checkOut("R4 parallel hold after rise", {3'b000, 2'b10, 9'h123});

    // R3 hold after serial load falls
    pulseSerLoad();
    checkOut("R3 serial capture after parallel", {3'd6, 2'd3, 9'h0F0});
    sendFrame({3'd3, 2'd0, 9'h011});
    checkOut("R3 hold after fall", {3'd6, 2'd3, 9'h0F0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule